// File: doc/BRIEF.md
# Password-Gated Clock Manager Register File

This block holds the 32-bit control words of a clock manager behind a simple request/response port that covers an 8 KiB byte window. A write only lands when its top byte carries a magic key. The stored copy always has that key byte zeroed, so software reading a register back never sees the key. Accesses narrower than a full word, or not aligned to a word, are refused with a one-cycle error response.

One register is not stored state. It is a lock summary built on every read from two control words per PLL: the power-down bit in the PLL's analog control word, and the analog-reset bit in its manager control word.

Downstream divider and PLL logic does not poll the register file. Each accepted write produces a strobe carrying the register index. A write to a PLL's manager control word also produces a per-PLL pulse that tells that PLL, and every channel fed by it, to re-evaluate.

Top module: `clkmgr_regs`

## Requirements
- R1: After reset, every stored word is zero except the five PLL analog control words (indices 16 to 20), which hold 0x0001_0000 (power-down bit 16 set); the lock summary therefore reads zero.
- R2: A legal write whose bits 31:24 differ from the key (default 0x5A) changes no stored word, raises no strobe and completes with no error.
- R3: A write carrying the key stores the data with bits 31:24 forced to zero.
- R4: An access is legal only with byte enables 4'hF and byte address bits 1:0 equal to zero. Any other access answers with the error flag for one cycle, read data zero, no strobe and no change of any stored word.
- R5: The register index is the byte address bits 12:2. Indices of 32 or more read as zero, and writes to them change nothing and raise no strobe.
- R6: A read of index 2 (byte 0x008) returns, in bit 8+p, a one exactly when PLL p has bit 16 of word 16+p clear and bit 8 of word 8+p clear. All other bits read zero, whatever was written there.
- R7: A read of any other in-range index returns the stored word.
- R8: An accepted write to manager control word 8+p pulses bit p of the PLL update output for one cycle, in the response cycle; at most one bit is ever high.
- R9: Every accepted in-range write pulses the write strobe for one cycle in the response cycle, with the written index beside it.
- R10: The request ready output is always high. Every request is answered by exactly one response-valid cycle, on the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address in the window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data including key byte |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 32 | Read data |
| wr_stb | output | 1 | Accepted write pulse |
| wr_index | output | 11 | Index of the accepted write |
| pll_upd | output | 5 | Per-PLL re-evaluate pulse |

## Verification
A corrupted stored word shows up at the next read of that index. For a PLL control word it shows up sooner, in the lock summary, because that summary is built combinationally from the stored bits and appears one cycle after the read request. A wrong key comparison or a missed key strip is visible on the very next readback. An error path that leaks into storage is caught by reading the target word after the refused access. A strobe decode that is off by one fires the wrong bit of the update output in the same response cycle.

// File: rtl/clkmgr_pkg.sv
package clkmgr_pkg;
  localparam int ADDR_W = 13;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int KEY_W  = 8;

  // key carried in the top byte of every write
  function automatic logic key_match(logic [31:0] data, logic [KEY_W-1:0] key);
    return data[31:32-KEY_W] == key;
  endfunction

  function automatic logic [31:0] strip_key(logic [31:0] data);
    return {{KEY_W{1'b0}}, data[31-KEY_W:0]};
  endfunction

  function automatic logic pll_locked(logic pwrdn, logic anarst);
    return !pwrdn && !anarst;
  endfunction
endpackage

// File: rtl/clkmgr_access_check.sv
module clkmgr_access_check
  import clkmgr_pkg::*;
#(
  parameter int          NUM_REGS = 32,
  parameter logic [7:0]  KEY      = 8'h5A
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic              legal,
  output logic              key_ok,
  output logic              in_range,
  output logic [IDX_W-1:0]  index
);
  assign index    = addr[ADDR_W-1:2];
  assign legal    = (be == 4'hF) && (addr[1:0] == 2'b00);
  assign key_ok   = key_match(wdata, KEY);
  assign in_range = 32'(index) < NUM_REGS;
endmodule

// File: rtl/clkmgr_lock_compose.sv
module clkmgr_lock_compose
  import clkmgr_pkg::*;
#(
  parameter int NUM_PLL    = 5,
  parameter int LOCK_LSB   = 8,
  parameter int ANARST_BIT = 8,
  parameter int PWRDN_BIT  = 16
) (
  input  logic [NUM_PLL-1:0][31:0] cm_words,
  input  logic [NUM_PLL-1:0][31:0] ana_words,
  output logic [31:0]              lock_word
);
  logic [NUM_PLL-1:0] locked;

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    assign locked[p] = pll_locked(ana_words[p][PWRDN_BIT], cm_words[p][ANARST_BIT]);
  end

  assign lock_word = 32'(locked) << LOCK_LSB;
endmodule

// File: rtl/clkmgr_regfile.sv
module clkmgr_regfile #(
  parameter int NUM_REGS  = 32,
  parameter int NUM_PLL   = 5,
  parameter int CM_BASE   = 8,
  parameter int ANA_BASE  = 16,
  parameter int PWRDN_BIT = 16,
  localparam int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [31:0]              wr_data,
  input  logic [SEL_W-1:0]         rd_sel,
  output logic [31:0]              rd_word,
  output logic [NUM_PLL-1:0][31:0] cm_words,
  output logic [NUM_PLL-1:0][31:0] ana_words
);
  localparam logic [31:0] ANA_RST = 32'(1) << PWRDN_BIT;

  function automatic logic [31:0] reset_value(int i);
    return (i >= ANA_BASE && i < ANA_BASE + NUM_PLL) ? ANA_RST : 32'h0;
  endfunction

  logic [31:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= reset_value(i);
    end else if (wr_en) begin
      regs[wr_sel] <= wr_data;
    end
  end

  assign rd_word = regs[rd_sel];

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_taps
    assign cm_words[p]  = regs[CM_BASE + p];
    assign ana_words[p] = regs[ANA_BASE + p];
  end

  // R3: the top level must never hand a key byte to storage
  a_r3_key_stripped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data[31:24] == 8'h00));
endmodule

// File: rtl/clkmgr_regs.sv
module clkmgr_regs
  import clkmgr_pkg::*;
#(
  parameter int         NUM_PLL    = 5,
  parameter int         NUM_REGS   = 32,
  parameter logic [7:0] KEY        = 8'h5A,
  parameter int         LOCK_IDX   = 2,
  parameter int         LOCK_LSB   = 8,
  parameter int         CM_BASE    = 8,
  parameter int         ANA_BASE   = 16,
  parameter int         ANARST_BIT = 8,
  parameter int         PWRDN_BIT  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [12:0]        req_addr,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [31:0]        rsp_rdata,
  output logic               wr_stb,
  output logic [10:0]        wr_index,
  output logic [NUM_PLL-1:0] pll_upd
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic             legal, key_ok, in_range;
  logic [IDX_W-1:0] index;
  logic             take, do_write, do_read;
  logic [31:0]      stored_word, lock_word, read_val;
  logic [NUM_PLL-1:0][31:0] cm_words, ana_words;
  logic [NUM_PLL-1:0] upd_hit;

  clkmgr_access_check #(.NUM_REGS(NUM_REGS), .KEY(KEY)) u_check (
    .addr(req_addr), .be(req_be), .wdata(req_wdata),
    .legal(legal), .key_ok(key_ok), .in_range(in_range), .index(index)
  );

  assign req_ready = 1'b1;
  assign take      = req_valid && req_ready;
  assign do_write  = take && req_write && legal && key_ok && in_range;
  assign do_read   = take && !req_write && legal;

  clkmgr_regfile #(
    .NUM_REGS(NUM_REGS), .NUM_PLL(NUM_PLL), .CM_BASE(CM_BASE),
    .ANA_BASE(ANA_BASE), .PWRDN_BIT(PWRDN_BIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(do_write), .wr_sel(index[SEL_W-1:0]), .wr_data(strip_key(req_wdata)),
    .rd_sel(index[SEL_W-1:0]), .rd_word(stored_word),
    .cm_words(cm_words), .ana_words(ana_words)
  );

  clkmgr_lock_compose #(
    .NUM_PLL(NUM_PLL), .LOCK_LSB(LOCK_LSB),
    .ANARST_BIT(ANARST_BIT), .PWRDN_BIT(PWRDN_BIT)
  ) u_lock (
    .cm_words(cm_words), .ana_words(ana_words), .lock_word(lock_word)
  );

  always_comb begin
    if (!in_range)                     read_val = 32'h0;
    else if (32'(index) == LOCK_IDX)   read_val = lock_word;
    else                               read_val = stored_word;
  end

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_upd
    assign upd_hit[p] = do_write && (32'(index) == CM_BASE + p);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= 32'h0;
      wr_stb    <= 1'b0;
      wr_index  <= '0;
      pll_upd   <= '0;
    end else begin
      rsp_valid <= take;
      rsp_err   <= take && !legal;
      rsp_rdata <= do_read ? read_val : 32'h0;
      wr_stb    <= do_write;
      wr_index  <= do_write ? index : '0;
      pll_upd   <= upd_hit;
    end
  end

  a_r10_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r4_error_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !wr_stb && (rsp_rdata == 32'h0));
  a_r8_single_pll: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pll_upd));
  a_r8_upd_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|pll_upd) |-> wr_stb);
  a_r9_strobe_in_response: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> rsp_valid && !rsp_err);
endmodule

// File: tb/test_clkmgr_regs.sv
module test_clkmgr_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, wr_stb;
  logic [31:0] rsp_rdata;
  logic [10:0] wr_index;
  logic [4:0]  pll_upd;

  int checks = 0, fails = 0;
  logic        r_valid, r_err, r_stb;
  logic [31:0] r_data;
  logic [10:0] r_idx;
  logic [4:0]  r_upd;

  always #2.5 clk = ~clk;

  clkmgr_regs i_clkmgr_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .wr_stb(wr_stb), .wr_index(wr_index), .pll_upd(pll_upd)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(logic wr, logic [12:0] addr, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    r_valid = rsp_valid; r_err = rsp_err; r_data = rsp_rdata;
    r_stb = wr_stb; r_idx = wr_index; r_upd = pll_upd;
    check("R10 response valid", 32'(r_valid), 1);
  endtask

  task automatic rd(logic [12:0] addr); access(1'b0, addr, 4'hF, 32'h0); endtask
  task automatic wr(logic [12:0] addr, logic [31:0] d); access(1'b1, addr, 4'hF, d); endtask

  function automatic logic [31:0] lock_bits(logic [4:0] m);
    return {19'd0, m, 8'd0};
  endfunction

  task automatic t_reset;
    check("R10 ready", 32'(req_ready), 1);
    rd(13'h020); check("R1 manager word zero", r_data, 0);
    rd(13'h040); check("R1 analog word powered down", r_data, 32'h0001_0000);
    rd(13'h050); check("R1 last analog word", r_data, 32'h0001_0000);
    rd(13'h008); check("R1 R6 lock zero at reset", r_data, 0);
  endtask

  task automatic t_key;
    wr(13'h024, 32'h1100_ABCD);
    check("R2 no error", 32'(r_err), 0);
    check("R2 no strobe", 32'(r_stb), 0);
    check("R2 no pll pulse", 32'(r_upd), 0);
    rd(13'h024); check("R2 word unchanged", r_data, 0);
  endtask

  task automatic t_strip;
    wr(13'h060, 32'h5AFF_1234);
    check("R9 strobe", 32'(r_stb), 1);
    check("R9 index", 32'(r_idx), 24);
    check("R8 generic word no pll pulse", 32'(r_upd), 0);
    rd(13'h060); check("R3 R7 key byte cleared", r_data, 32'h00FF_1234);
  endtask

  task automatic t_illegal;
    access(1'b1, 13'h061, 4'hF, 32'h5A00_0001);
    check("R4 unaligned error", 32'(r_err), 1);
    check("R4 unaligned no strobe", 32'(r_stb), 0);
    access(1'b1, 13'h060, 4'h3, 32'h5A00_0002);
    check("R4 narrow write error", 32'(r_err), 1);
    access(1'b0, 13'h060, 4'h1, 32'h0);
    check("R4 narrow read error", 32'(r_err), 1);
    check("R4 narrow read data zero", r_data, 0);
    rd(13'h060);
    check("R4 word unchanged", r_data, 32'h00FF_1234);
    check("R4 legal read no error", 32'(r_err), 0);
    @(negedge clk);
    check("R4 error lasts one cycle", 32'(rsp_err), 0);
  endtask

  task automatic t_range;
    wr(13'h1000, 32'h5A00_7777);
    check("R5 no strobe out of range", 32'(r_stb), 0);
    rd(13'h1000); check("R5 reads zero", r_data, 0);
    rd(13'h07C); check("R5 R7 last in-range word", r_data, 0);
  endtask

  task automatic t_lock;
    wr(13'h044, 32'h5A00_0000);
    check("R8 analog word no pll pulse", 32'(r_upd), 0);
    rd(13'h008); check("R6 pll1 locked", r_data, lock_bits(5'b00010));
    wr(13'h024, 32'h5A00_0100);
    check("R8 pulse pll1", 32'(r_upd), 32'b00010);
    check("R9 index of manager word", 32'(r_idx), 9);
    @(negedge clk);
    check("R8 pulse one cycle", 32'(pll_upd), 0);
    rd(13'h008); check("R6 analog reset unlocks", r_data, 0);
    wr(13'h024, 32'h5A00_0000);
    wr(13'h050, 32'h5A00_0000);
    rd(13'h008); check("R6 pll1 and pll4", r_data, lock_bits(5'b10010));
    wr(13'h030, 32'h5A00_0000);
    check("R8 pulse pll4", 32'(r_upd), 32'b10000);
    wr(13'h008, 32'h5A00_FFFF);
    rd(13'h008); check("R6 lock stays live", r_data, lock_bits(5'b10010));
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_key;
    t_strip;
    t_illegal;
    t_range;
    t_lock;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule